// File: doc/BRIEF.md
# Serial Character FIFO Pair with Trigger Interrupts

This block buffers characters between a bus master and the shift logic of a serial port. A 16-entry, 8-bit queue holds characters waiting to be sent. A second 16-entry queue holds received characters, and each of its entries also stores three line-error flags. Each queue has a selectable fill threshold that raises an interrupt source. One control bit reduces both queues to a single entry each, which gives a plain holding-register interface.

Four interrupt sources are latched in a raw status register:
- receive threshold,
- transmit threshold,
- received-character error,
- receive overrun.

Each source has its own mask bit. The unmasked sources are OR-ed onto one interrupt line. A register port gives access to data, status, control, mask, masked status and write-one-to-clear. The baud timing and the bit shifting are outside this block. On the receive side, that logic offers characters on `rx_valid`. On the transmit side, it takes the queue head with `tx_take`.

Register map, selected by `bus_addr`:

| Address | Read | Write |
|---|---|---|
| 0 | Head of the receive queue, and pops it | Pushes a character into the transmit queue |
| 1 | Error flags of the receive head, `{5'b0, break, parity, framing}`; no pop | — |
| 2 | Status: bit0 transmit empty, bit1 transmit full, bit2 receive empty, bit3 receive full | — |
| 3 | Control | Control |
| 4 | Mask, bits 3:0 | Mask, bits 3:0 |
| 5 | Raw status | Write-one-to-clear |
| 6 | Masked status | — |

Control register (address 3):
- bit0: deep mode. 1 gives 16 entries, 0 gives 1 entry.
- bits 3:1: transmit level code.
- bits 6:4: receive level code.

Raw, mask and masked status share one bit layout: bit0 receive threshold, bit1 transmit threshold, bit2 error, bit3 overrun.

Top module: `serial_fifo_irq`

## Requirements
- R1: Each queue returns characters in the order they entered, up to 16 entries in deep mode. Address 1 returns the error flags stored with the current receive head, as `{5'b0, break, parity, framing}`.
- R2: A transmit push while the queue is full is discarded. A receive pop (read of address 0) or a `tx_take` on an empty queue changes nothing. The status register at address 2 uses bit0 = transmit empty, bit1 = transmit full, bit2 = receive empty, bit3 = receive full.
- R3: A character offered on `rx_valid` while the receive queue is full is discarded, and raw bit3 (overrun) is set in the same clock edge.
- R4: Receive level codes 0, 1, 2, 3 and 4 give thresholds of 2, 4, 8, 12 and 14 entries; codes 5 to 7 act as 14. Raw bit0 is set one cycle after the receive fill level first reaches or exceeds the threshold.
- R5: Transmit level codes use the same thresholds as R4. Raw bit1 is set one cycle after the transmit fill level first drops to or below the threshold. The state present at reset does not count as such a drop.
- R6: With control bit0 = 0, each queue holds one entry. Raw bit0 is then set one cycle after the receive entry fills, and raw bit1 one cycle after the transmit entry empties.
- R7: A stored receive character with any error flag set raises raw bit2 in the same clock edge.
- R8: Writing address 5 clears each raw bit written as 1. Other raw bits keep their value.
- R9: `irq` is high exactly when some raw bit is set and its mask bit at address 4 is 1. Address 6 reads the raw bits ANDed with the mask.
- R10: After reset both queues are empty (status 0x05), raw and mask are 0, `irq` is low, and control reads 0x25 (deep mode, both level codes 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on address 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tx_data | output | 8 | Head of transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Shifter consumes transmit head |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | {break, parity, framing} flags of the received character |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong fill count shows up at the ports as early as the next character. The status bits move, a threshold source fires on the wrong entry, or a push or overrun is misjudged. The bench therefore checks `irq` after every single receive character for each level code, so an off-by-one threshold appears at the exact entry where it goes wrong. A wrong pointer shows up as a wrong character at the head. Every character is compared on its way out, so a broken order or a stored overrun character is seen on the first read that returns it.

// File: rtl/serial_fifo_irq.sv
module serial_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [2:0]   bus_addr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  output logic [W-1:0] tx_data,
  output logic         tx_avail,
  input  logic         tx_take,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic [2:0]   rx_err,
  output logic         irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [CW-1:0] level(input logic [2:0] code);
    case (code)
      3'd0:    level = CW'(DEPTH / 8);
      3'd1:    level = CW'(DEPTH / 4);
      3'd2:    level = CW'(DEPTH / 2);
      3'd3:    level = CW'(DEPTH * 3 / 4);
      default: level = CW'(DEPTH * 7 / 8);
    endcase
  endfunction

  logic [W-1:0]   tx_mem [DEPTH];
  logic [W+2:0]   rx_mem [DEPTH];
  logic [AW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]  tx_cnt, rx_cnt, lim;
  logic [6:0]     ctrl;
  logic [3:0]     mask, raw, set, clr;
  logic           rx_cond_q, tx_cond_q;

  wire deep     = ctrl[0];
  assign lim    = deep ? CW'(DEPTH) : CW'(1);

  wire tx_empty = (tx_cnt == '0);
  wire rx_empty = (rx_cnt == '0);
  wire tx_full  = (tx_cnt >= lim);
  wire rx_full  = (rx_cnt >= lim);

  wire tx_push  = bus_wr && bus_addr == 3'd0 && !tx_full;
  wire tx_pop   = tx_take && !tx_empty;
  wire rx_push  = rx_valid && !rx_full;
  wire rx_pop   = bus_rd && bus_addr == 3'd0 && !rx_empty;

  wire rx_cond  = deep ? (rx_cnt >= level(ctrl[6:4])) : !rx_empty;
  wire tx_cond  = deep ? (tx_cnt <= level(ctrl[3:1])) : tx_empty;

  assign set = {rx_valid && rx_full,
                rx_push && (|rx_err),
                tx_cond && !tx_cond_q,
                rx_cond && !rx_cond_q};
  assign clr = (bus_wr && bus_addr == 3'd5) ? bus_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[W-1:0];
    if (rx_push) rx_mem[rx_wp] <= {rx_err, rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      ctrl <= 7'h25; mask <= '0; raw <= '0;
      rx_cond_q <= 1'b0; tx_cond_q <= 1'b1;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (bus_wr && bus_addr == 3'd3) ctrl <= bus_wdata[6:0];
      if (bus_wr && bus_addr == 3'd4) mask <= bus_wdata[3:0];
      raw <= (raw & ~clr) | set;
      rx_cond_q <= rx_cond;
      tx_cond_q <= tx_cond;
    end
  end

  assign tx_data  = tx_mem[tx_rp];
  assign tx_avail = !tx_empty;
  assign irq      = |(raw & mask);

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = 8'(rx_mem[rx_rp][W-1:0]);
      3'd1:    bus_rdata = {5'd0, rx_mem[rx_rp][W+2:W]};
      3'd2:    bus_rdata = {4'd0, rx_full, rx_empty, tx_full, tx_empty};
      3'd3:    bus_rdata = {1'b0, ctrl};
      3'd4:    bus_rdata = {4'd0, mask};
      3'd5:    bus_rdata = {4'd0, raw};
      3'd6:    bus_rdata = {4'd0, raw & mask};
      default: bus_rdata = 8'd0;
    endcase
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));
  assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full |=> raw[3]);
  assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full && !rx_pop |=> $stable(rx_cnt));
  assert_tx_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_cond) |=> raw[1]);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 4'd0 |-> !irq);
endmodule

// File: tb/serial_fifo_irq_bench.sv
module serial_fifo_irq_bench;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, tx_take = 0, rx_valid = 0;
  logic [2:0] bus_addr = 0, rx_err = 0;
  logic [7:0] bus_wdata = 0, rx_data = 0, bus_rdata, tx_data;
  logic tx_avail, irq;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  serial_fifo_irq u_serial_fifo_irq (.*);

  // {receive level code, expected threshold}
  localparam logic [7:0] RXV [6] = '{{3'd0, 5'd2}, {3'd1, 5'd4}, {3'd2, 5'd8},
                                     {3'd3, 5'd12}, {3'd4, 5'd14}, {3'd7, 5'd14}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rx_in(input logic [7:0] c, input logic [2:0] e);
    rx_valid = 1; rx_data = c; rx_err = e;
    @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask

  task automatic take(output logic [7:0] d);
    d = tx_data; tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    rd(3'd2, rv); check("R10 status", rv, 8'h05);
    rd(3'd3, rv); check("R10 ctrl", rv, 8'h25);
    rd(3'd5, rv); check("R10 raw", rv, 0);
    rd(3'd4, rv); check("R10 mask", rv, 0);
    check("R10 irq", irq, 0);

    // R4 receive thresholds from the vector table
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(3'd3, {1'b0, RXV[i][7:5], 3'b010, 1'b1});
      wr(3'd4, 8'h01);
      for (int n = 1; n <= 16; n++) begin
        rx_in(8'(n), 3'd0);
        idle();
        check("R4 rx trigger", irq, (n >= int'(RXV[i][4:0])) ? 1 : 0);
      end
    end

    // R1 R3 overrun: 17th character dropped, flag set
    do_reset();
    wr(3'd4, 8'h08);
    for (int n = 0; n < 16; n++) rx_in(8'(8'h40 + n), 3'd0);
    check("R3 no overrun yet", irq, 0);
    rd(3'd2, rv); check("R2 rx full status", rv, 8'h09);
    rx_in(8'hEE, 3'd0);
    check("R3 overrun irq", irq, 1);
    rd(3'd6, rv); check("R9 masked status", rv, 8'h08);
    rd(3'd5, rv); check("R4 raw rx bit with overrun", rv, 8'h09);
    for (int n = 0; n < 16; n++) begin
      rd(3'd0, rv); check("R1 R3 rx order", rv, 8'h40 + n);
    end
    rd(3'd2, rv); check("R3 dropped char absent", rv, 8'h05);
    rd(3'd0, rv);
    rd(3'd2, rv); check("R2 pop empty ignored", rv, 8'h05);

    // R8 write-one-to-clear
    wr(3'd5, 8'h08);
    rd(3'd5, rv); check("R8 clear selected bit", rv, 8'h01);
    check("R8 irq low after clear", irq, 0);

    // R7 error flag stored and raised
    wr(3'd4, 8'h04);
    rx_in(8'h5A, 3'b010);
    check("R7 error irq", irq, 1);
    rd(3'd1, rv); check("R1 head flags", rv, 8'h02);
    rd(3'd0, rv); check("R1 head data", rv, 8'h5A);
    wr(3'd4, 8'h00);
    check("R9 masked off", irq, 0);

    // R2 transmit overflow and order
    do_reset();
    for (int n = 0; n < 17; n++) wr(3'd0, 8'(8'h80 + n));
    rd(3'd2, rv); check("R2 tx full status", rv, 8'h06);
    for (int n = 0; n < 16; n++) begin
      take(rv); check("R1 R2 tx order", rv, 8'h80 + n);
    end
    check("R2 tx empty", tx_avail, 0);
    take(rv);
    rd(3'd2, rv); check("R2 take empty ignored", rv, 8'h05);

    // R5 transmit threshold (code 0 -> 2)
    do_reset();
    wr(3'd3, 8'h21);
    wr(3'd4, 8'h02);
    for (int n = 0; n < 5; n++) wr(3'd0, 8'(n));
    wr(3'd5, 8'h0F);
    idle();
    check("R5 no trigger above level", irq, 0);
    take(rv); idle(); check("R5 cnt 4", irq, 0);
    take(rv); idle(); check("R5 cnt 3", irq, 0);
    take(rv); idle(); check("R5 cnt 2 trigger", irq, 1);

    // R6 single-entry mode
    do_reset();
    wr(3'd3, 8'h24);
    wr(3'd4, 8'h03);
    rx_in(8'h11, 3'd0); idle();
    check("R6 rx single trigger", irq, 1);
    rx_in(8'h22, 3'd0);
    rd(3'd5, rv); check("R6 single overrun", rv & 8'h09, 8'h09);
    rd(3'd0, rv); check("R6 kept first char", rv, 8'h11);
    wr(3'd5, 8'h0F);
    wr(3'd0, 8'hA1);
    wr(3'd0, 8'hA2);
    rd(3'd2, rv); check("R6 tx one entry full", rv, 8'h06);
    take(rv); check("R6 tx char", rv, 8'hA1);
    idle();
    rd(3'd5, rv); check("R6 tx empty trigger", rv & 8'h02, 8'h02);
    check("R6 tx drained", tx_avail, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule